// File: doc/BRIEF.md
# Timer Port Pin Multiplexer

This block sits between an eight-pin port and a timer core. It decides, pin by pin, whether the pad is driven by a software-written output latch or by the timer's compare logic. It also turns selected input transitions into capture events and assembles the word that software reads from the port. The timer core supplies one match strobe per compare channel and a match strobe for a master compare channel. The block returns capture events, pad drive values with their output enables, and the read word.

The low three pins are capture inputs. Each has an edge detector that sits behind a synchronizer. The middle three pins are outputs, and each is owned by one compare channel. Pin 3 is a shared pin that can be an I/O, a fourth capture input, or the output of a fifth compare channel. Pin 7 is an I/O whose synchronized level also feeds a pulse accumulator. A master compare channel has a five-bit mask and a five-bit data word covering pins 3 to 7. On its match strobe it forces every masked pin that is currently driving to its data value, and it wins over any per-pin action in the same cycle.

Top module: `timer_port_mux`

## Requirements
- R1: The edge select holds two bits per capture pin, at bits [2c+1:2c] for pin c. The codes are 00 off, 01 rising, 10 falling and 11 both. A selected transition on pinIn raises capEvt[c] for exactly one cycle, two clock edges after the input changes.
- R2: rdData[2:0] always shows the synchronized level of pins 0 to 2, including while those pins are being used for capture.
- R3: Compare channels 2, 3, 4 and 5 drive pins 6, 5, 4 and 3. Their action fields are cmpAct[1:0], [3:2], [5:4] and [7:6], and their match strobes are cmpMatch[0] to cmpMatch[3]. The action codes are 00 no effect, 01 toggle, 10 clear and 11 set.
- R4: p3Mode selects the role of pin 3: 00 I/O with direction gpioDir[0] (1 means output), 01 capture input 4, 10 output of compare channel 5, and 11 the same as 00. capEvt[3] can fire only in mode 01, and pin 3 is never driven in that mode.
- R5: A port write updates, on the next clock edge, the latch of every pin from 3 to 7 that is not under timer control. A pin is under timer control when it is driving and either its mcMask bit is set or its compare channel is active. Writes to controlled pins leave them unchanged.
- R6: On mcMatch, each driving pin 3+k whose mcMask[k] is set loads mcData[k]. Unmasked pins are unaffected.
- R7: When mcMatch and a per-pin compare match hit the same pin in the same cycle, the pin takes the master data value.
- R8: Pin 7 drives when gpioDir[1] is 1. paIn always carries the synchronized level of pin 7.
- R9: For pins 3 to 7, rdData returns the output latch while the pin drives and the synchronized pad level while it does not.
- R10: While reset is held and after reset, all latches are 0 and capEvt is 0. pinOe is 1 for pins 4 to 6 and follows the configuration for pins 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Pad input levels |
| wrEn | input | 1 | Port data write strobe |
| wrData | input | 8 | Port data write value |
| edgeSel | input | 8 | Capture edge select, 2 bits per capture pin 0..3 |
| p3Mode | input | 2 | Role of pin 3 |
| gpioDir | input | 2 | I/O direction of pin 3 (bit 0) and pin 7 (bit 1) |
| cmpAct | input | 8 | Action fields of compare channels 2..5 |
| cmpMatch | input | 4 | Match strobes of compare channels 2..5 |
| mcMatch | input | 1 | Master compare match strobe |
| mcMask | input | 5 | Master compare pin mask, bit k = pin 3+k |
| mcData | input | 5 | Master compare data, bit k = pin 3+k |
| pinOut | output | 8 | Pad drive values |
| pinOe | output | 8 | Pad output enables |
| rdData | output | 8 | Port read word |
| capEvt | output | 4 | Capture events for pins 0..3 |
| paIn | output | 1 | Synchronized pin 7 level for the pulse accumulator |

## Verification
The bench builds the block with its default synchronizer depth of two stages. At that depth the capture latency is a fixed two edges, so every capture check can sample one exact cycle. That also exposes an event that is early, late, or held longer than a single cycle. A sequence held in a table drives compare channel 2 through all four action codes, combined with master matches. This brings the override ordering and the no-effect code within reach on a single pin, whose value carries over from one step to the next.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int PORT_W = 8;
  localparam int CAP_N  = 4;
  localparam int CMP_N  = 4;
  localparam int MC_W   = 5;
  localparam int MC_LO  = 3;

  typedef enum logic [1:0] {ACT_OFF = 2'b00, ACT_TGL = 2'b01, ACT_CLR = 2'b10, ACT_SET = 2'b11} cmpAct_e;
  typedef enum logic [1:0] {EDGE_OFF = 2'b00, EDGE_RISE = 2'b01, EDGE_FALL = 2'b10, EDGE_BOTH = 2'b11} edgeSel_e;
  typedef enum logic [1:0] {P3_GPIO = 2'b00, P3_CAP = 2'b01, P3_CMP = 2'b10, P3_RSV = 2'b11} p3Mode_e;

  typedef struct packed {
    logic [MC_W-1:0] loadMc;
    logic [MC_W-1:0] setBit;
    logic [MC_W-1:0] clrBit;
    logic [MC_W-1:0] tglBit;
    logic [MC_W-1:0] wrMask;
    logic [MC_W-1:0] oe;
  } portStrobe_t;
endpackage

// File: rtl/tport_ctrl.sv
module tport_ctrl
  import tport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PORT_W-1:0]     pinIn,
  input  logic [2*CAP_N-1:0]    edgeSel,
  input  logic [1:0]            p3Mode,
  input  logic [1:0]            gpioDir,
  input  logic [2*CMP_N-1:0]    cmpAct,
  input  logic [CMP_N-1:0]      cmpMatch,
  input  logic                  mcMatch,
  input  logic [MC_W-1:0]       mcMask,
  input  logic                  wrEn,
  output logic [PORT_W-1:0]     syncLvl,
  output logic [CAP_N-1:0]      capEvt,
  output portStrobe_t           strb
);
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevLvl <= syncQ[SYNC_STAGES-1];
    end
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  logic p3Cap, p3Cmp;
  assign p3Cap = (p3Mode == P3_CAP);
  assign p3Cmp = (p3Mode == P3_CMP);

  // capture edge detectors
  for (genvar c = 0; c < CAP_N; c++) begin : g_cap
    logic rise, fall, allow;
    logic [1:0] sel;
    assign sel   = edgeSel[2*c +: 2];
    assign rise  = syncLvl[c] & ~prevLvl[c];
    assign fall  = ~syncLvl[c] & prevLvl[c];
    assign allow = (c < CAP_N-1) ? 1'b1 : p3Cap;
    assign capEvt[c] = allow & (((sel == EDGE_RISE) & rise) |
                                ((sel == EDGE_FALL) & fall) |
                                ((sel == EDGE_BOTH) & (rise | fall)));

    assert_rise_level_R1: assert property (@(posedge clk) disable iff (!rstN)
      (capEvt[c] && sel == EDGE_RISE) |-> syncLvl[c]);
    assert_fall_level_R1: assert property (@(posedge clk) disable iff (!rstN)
      (capEvt[c] && sel == EDGE_FALL) |-> !syncLvl[c]);
  end

  // per-pin strobes for pins MC_LO .. MC_LO+MC_W-1
  for (genvar k = 0; k < MC_W; k++) begin : g_pin
    logic chanOn, ctl;
    if (k == 0) begin : g_p3
      assign strb.oe[k] = p3Cmp | (!p3Cap & gpioDir[0]);
    end else if (k == MC_W-1) begin : g_p7
      assign strb.oe[k] = gpioDir[1];
    end else begin : g_mid
      assign strb.oe[k] = 1'b1;
    end

    if (k < CMP_N) begin : g_chan
      localparam int CH = CMP_N - 1 - k;
      logic [1:0] act;
      logic hit;
      assign act    = cmpAct[2*CH +: 2];
      assign chanOn = (act != ACT_OFF) & ((k != 0) | p3Cmp);
      assign hit    = cmpMatch[CH] & chanOn & ~strb.loadMc[k];
      assign strb.setBit[k] = hit & (act == ACT_SET);
      assign strb.clrBit[k] = hit & (act == ACT_CLR);
      assign strb.tglBit[k] = hit & (act == ACT_TGL);
    end else begin : g_nochan
      assign chanOn = 1'b0;
      assign strb.setBit[k] = 1'b0;
      assign strb.clrBit[k] = 1'b0;
      assign strb.tglBit[k] = 1'b0;
    end

    assign ctl = strb.oe[k] & (mcMask[k] | chanOn);
    assign strb.loadMc[k] = mcMatch & mcMask[k] & strb.oe[k];
    assign strb.wrMask[k] = wrEn & ~ctl;
  end
endmodule

// File: rtl/tport_dp.sv
module tport_dp
  import tport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic [PORT_W-1:0] wrData,
  input  logic [MC_W-1:0]   mcData,
  input  logic [PORT_W-1:0] syncLvl,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] rdData
);
  logic [MC_W-1:0] outLat;

  for (genvar k = 0; k < MC_W; k++) begin : g_lat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                outLat[k] <= 1'b0;
      else if (strb.loadMc[k])  outLat[k] <= mcData[k];
      else if (strb.setBit[k])  outLat[k] <= 1'b1;
      else if (strb.clrBit[k])  outLat[k] <= 1'b0;
      else if (strb.tglBit[k])  outLat[k] <= ~outLat[k];
      else if (strb.wrMask[k])  outLat[k] <= wrData[MC_LO+k];
    end
    assign rdData[MC_LO+k] = strb.oe[k] ? outLat[k] : syncLvl[MC_LO+k];
  end

  assign rdData[MC_LO-1:0] = syncLvl[MC_LO-1:0];
  assign pinOut = {outLat, {MC_LO{1'b0}}};
  assign pinOe  = {strb.oe, {MC_LO{1'b0}}};

  assert_write_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.loadMc | strb.setBit | strb.clrBit | strb.tglBit) == '0)
      |=> ((outLat ^ $past(outLat)) & ~$past(strb.wrMask)) == '0);

  assert_master_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadMc != '0) |=> ((outLat & $past(strb.loadMc)) == ($past(mcData) & $past(strb.loadMc))));
endmodule

// File: rtl/timer_port_mux.sv
module timer_port_mux
  import tport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        pinIn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [7:0]        edgeSel,
  input  logic [1:0]        p3Mode,
  input  logic [1:0]        gpioDir,
  input  logic [7:0]        cmpAct,
  input  logic [3:0]        cmpMatch,
  input  logic              mcMatch,
  input  logic [4:0]        mcMask,
  input  logic [4:0]        mcData,
  output logic [7:0]        pinOut,
  output logic [7:0]        pinOe,
  output logic [7:0]        rdData,
  output logic [3:0]        capEvt,
  output logic              paIn
);
  portStrobe_t       strb;
  logic [PORT_W-1:0] syncLvl;

  tport_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .edgeSel(edgeSel), .p3Mode(p3Mode),
    .gpioDir(gpioDir), .cmpAct(cmpAct), .cmpMatch(cmpMatch), .mcMatch(mcMatch),
    .mcMask(mcMask), .wrEn(wrEn), .syncLvl(syncLvl), .capEvt(capEvt), .strb(strb)
  );

  tport_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .mcData(mcData),
    .syncLvl(syncLvl), .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData)
  );

  assign paIn = syncLvl[PORT_W-1];

  assert_toggle_pin6_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMatch[0] && cmpAct[1:0] == 2'b01 && !(mcMatch && mcMask[3])) |=> pinOut[6] != $past(pinOut[6]));

  assert_no_drive_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (p3Mode == 2'b01) |-> !pinOe[3]);
endmodule

// File: tb/timer_port_mux_tb.sv
`timescale 1ns/1ps
module timer_port_mux_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = '0, wrData = '0, edgeSel = '0, cmpAct = '0;
  logic wrEn = 1'b0, mcMatch = 1'b0;
  logic [1:0] p3Mode = '0, gpioDir = '0;
  logic [3:0] cmpMatch = '0;
  logic [4:0] mcMask = '0, mcData = '0;
  logic [7:0] pinOut, pinOe, rdData;
  logic [3:0] capEvt;
  logic paIn;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  timer_port_mux u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrData(wrData),
    .edgeSel(edgeSel), .p3Mode(p3Mode), .gpioDir(gpioDir), .cmpAct(cmpAct),
    .cmpMatch(cmpMatch), .mcMatch(mcMatch), .mcMask(mcMask), .mcData(mcData),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData), .capEvt(capEvt), .paIn(paIn)
  );

  // {act[1:0], mcHit, mcOn, mcDat, expected pin 6}
  localparam logic [5:0] VEC [10] = '{
    6'b01_000_1, 6'b01_000_0, 6'b11_000_1, 6'b11_000_1, 6'b00_000_1,
    6'b10_000_0, 6'b11_110_0, 6'b01_110_0, 6'b11_000_1, 6'b00_110_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    nxt(3);
    check("R10 reset pinOut", pinOut, 8'h00);
    check("R10 reset capEvt", capEvt, 4'h0);
    check("R10 reset pinOe", pinOe, 8'h70);
    rstN = 1'b1;
    nxt(2);
    check("R10 after reset rdData", rdData, 8'h00);

    // R3 R6 R7: action sequence on pin 6
    foreach (VEC[i]) begin
      cmpAct[1:0] = VEC[i][5:4];
      mcMatch = VEC[i][3];
      mcMask[3] = VEC[i][2];
      mcData[3] = VEC[i][1];
      cmpMatch[0] = 1'b1;
      nxt(1);
      cmpMatch = '0; mcMatch = 1'b0; mcMask = '0; mcData = '0;
      check($sformatf("R3/R7 vector %0d pin6", i), pinOut[6], VEC[i][0]);
    end
    cmpAct = '0;

    // R5 R9: writes to free pins, then to a controlled pin
    gpioDir = 2'b11;
    nxt(1);
    check("R4 R8 oe as outputs", pinOe, 8'hF8);
    wrEn = 1'b1; wrData = 8'hFF; nxt(1); wrEn = 1'b0;
    check("R5 R9 write all", rdData, 8'hF8);
    cmpAct[3:2] = 2'b01;
    wrEn = 1'b1; wrData = 8'h00; nxt(1); wrEn = 1'b0;
    check("R5 write ignored on pin5", pinOut, 8'h20);

    // R6 R5: master on pins 3 and 7 with a simultaneous write
    cmpAct = '0; mcMask = 5'b10001; mcData = 5'b11111;
    mcMatch = 1'b1; wrEn = 1'b1; wrData = 8'h00;
    nxt(1);
    mcMatch = 1'b0; wrEn = 1'b0; mcMask = '0; mcData = '0;
    check("R6 master masked pins", pinOut, 8'h88);

    // R1 R2: capture edges on pins 0..2
    edgeSel = 8'h39;
    pinIn = 8'h07;
    nxt(2);
    check("R1 rising/both events", capEvt, 4'b0101);
    check("R2 read capture levels", rdData, 8'h8F);
    nxt(1);
    check("R1 single cycle pulse", capEvt, 4'b0000);
    pinIn = 8'h00;
    nxt(2);
    check("R1 falling/both events", capEvt, 4'b0110);
    nxt(1);

    // R4: pin 3 as capture input
    p3Mode = 2'b01; edgeSel = 8'h79;
    nxt(1);
    check("R4 pin3 capture oe", pinOe, 8'hF0);
    pinIn[3] = 1'b1;
    nxt(2);
    check("R4 capture4 event", capEvt, 4'b1000);
    check("R9 pin3 input level", rdData[3], 1'b1);
    nxt(1);
    p3Mode = 2'b00; gpioDir[0] = 1'b0; edgeSel = 8'hF9;
    pinIn[3] = 1'b0;
    nxt(2);
    check("R4 no capture in gpio mode", capEvt, 4'b0000);
    check("R9 pin3 reads level not latch", rdData, 8'h80);

    // R4 R3: pin 3 as compare 5 output
    p3Mode = 2'b10; cmpAct = 8'h80; cmpMatch = 4'b1000;
    nxt(1); cmpMatch = '0;
    check("R3 ch5 clear pin3", pinOut[3], 1'b0);
    check("R4 pin3 compare oe", pinOe[3], 1'b1);
    cmpAct = 8'hC0; cmpMatch = 4'b1000;
    nxt(1); cmpMatch = '0;
    check("R3 ch5 set pin3", pinOut, 8'h88);

    // R8: pin 7 as input
    gpioDir[1] = 1'b0;
    pinIn[7] = 1'b1;
    nxt(2);
    check("R8 paIn follows pin7", paIn, 1'b1);
    check("R8 pin7 not driven", pinOe[7], 1'b0);
    pinIn[7] = 1'b0;
    nxt(2);
    check("R8 R9 pin7 reads level", rdData[7], 1'b0);
    check("R8 paIn low", paIn, 1'b0);

    // R10: reset in mid-run
    rstN = 1'b0;
    nxt(1);
    check("R10 mid reset pinOut", pinOut, 8'h00);
    check("R10 mid reset capEvt", capEvt, 4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule